// File: doc/BRIEF.md
# CAN Frame Counter and Timestamp Unit

This block holds the per-node 16-bit counter of a CAN controller. It has two uses. It can count completed frames, or it can act as a bit-time clock that timestamps the moment each frame begins. A two-bit mode input selects the behaviour. In counting mode a separate two-bit source select decides whether transmitted frames, received frames, or both advance the count.

After a transfer completes, the block issues a one-cycle write strobe to message object storage. The strobe carries the object index that came with the success strobe and the value to store:
- In counting mode the value is the freshly incremented count.
- In timestamp mode the value is the count captured when the frame started.

A frame that starts but never reports success leaves no write behind. When the counter wraps, a one-cycle overflow pulse goes to the interrupt logic. The bit engine, object storage and baud-rate analysis live elsewhere. The bit-timing mode codes only freeze the counter.

Top module: `can_frame_stamp`

## Requirements
- R1: After reset the counter and the capture register (`cap_val_o`) are 0, and `mo_wr_o` and `ovf_o` are low.
- R2: With `mode_i` = 2'b00 (counting), a success strobe increments the counter by one when its source is enabled: `cnt_src_i[0]` enables transmit (`tx_ok_i`) and `cnt_src_i[1]` enables receive (`rx_ok_i`). Transmit and receive strobes in the same cycle increment the counter only once.
- R3: In counting mode, the cycle after a counted success has `mo_wr_o` high for exactly one cycle. In that cycle `mo_val_o` equals the incremented count and `mo_idx_o` equals the `obj_idx_i` sampled with the strobe.
- R4: In counting mode, a success strobe from a disabled source changes neither the counter nor `mo_wr_o`.
- R5: With `mode_i` = 2'b01 (timestamp), each `bit_start_i` pulse increments the counter. Success strobes do not change the counter.
- R6: In timestamp mode, `frame_start_i` loads the counter value into `cap_val_o` on the next cycle. If `bit_start_i` is high in the same cycle, the value loaded is the one from before that increment.
- R7: In timestamp mode, a success strobe that follows a captured frame start gives a one-cycle `mo_wr_o` on the next cycle, with `mo_val_o` equal to `cap_val_o` and `mo_idx_o` equal to the supplied index.
- R8: In timestamp mode, a success strobe with no frame start since the last write issues no write. After an aborted frame, the next frame start overwrites the capture.
- R9: When the counter increments from 0xFFFF it becomes 0x0000. In the same cycle in which the counter shows 0, `ovf_o` is high for exactly one cycle.
- R10: With `mode_i` = 2'b10 or 2'b11 (bit timing), the counter holds, `cap_val_o` holds, and no `mo_wr_o` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 count, 01 timestamp, 10/11 bit timing (hold) |
| cnt_src_i | input | 2 | Count sources: bit0 transmit, bit1 receive |
| bit_start_i | input | 1 | Start of a new bit time |
| frame_start_i | input | 1 | Frame transmit or receive begins |
| tx_ok_i | input | 1 | Transmit completed successfully |
| rx_ok_i | input | 1 | Receive completed successfully |
| obj_idx_i | input | 6 | Message object index given with the success strobe |
| cap_val_o | output | 16 | Captured frame-start count |
| mo_wr_o | output | 1 | One-cycle write strobe to message object storage |
| mo_idx_o | output | 6 | Object index for the write |
| mo_val_o | output | 16 | Counter value to store in the object |
| ovf_o | output | 1 | One-cycle counter wrap pulse |

## Verification
The hardest event to reach is the counter wrap. Only counter increments move the count toward 0xFFFF, and the count itself can be seen only through the capture or the write value. The bench therefore runs timestamp mode with a bit-time pulse on every cycle for about 65,500 cycles. It then reads the count through a frame start just before and just after the wrap, and checks that the overflow pulse falls exactly on the wrap cycle. The aborted-frame case is reached by issuing a frame start with no success strobe and then a new frame start whose captured value must replace the old one.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [1:0] {
    FC_COUNT  = 2'b00,
    FC_STAMP  = 2'b01,
    FC_BTIME0 = 2'b10,
    FC_BTIME1 = 2'b11
  } fc_mode_e;

  localparam int unsigned FC_SRC_TX = 0;
  localparam int unsigned FC_SRC_RX = 1;

endpackage

// File: rtl/fc_ctrl.sv
module fc_ctrl
  import fc_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic [1:0] cnt_src_i,
  input  logic       bit_start_i,
  input  logic       frame_start_i,
  input  logic       tx_ok_i,
  input  logic       rx_ok_i,
  output logic       stamp_mode_o,
  output logic       inc_o,
  output logic       cap_en_o,
  output logic       cnt_wr_o,
  output logic       stamp_wr_req_o
);

  logic count_mode;
  logic counted_ok;
  logic any_ok;

  always_comb begin
    count_mode   = (fc_mode_e'(mode_i) == FC_COUNT);
    stamp_mode_o = (fc_mode_e'(mode_i) == FC_STAMP);
    any_ok       = tx_ok_i | rx_ok_i;
    counted_ok   = (tx_ok_i & cnt_src_i[FC_SRC_TX]) |
                   (rx_ok_i & cnt_src_i[FC_SRC_RX]);

    inc_o          = 1'b0;
    cap_en_o       = 1'b0;
    cnt_wr_o       = 1'b0;
    stamp_wr_req_o = 1'b0;

    if (count_mode) begin
      inc_o    = counted_ok;
      cnt_wr_o = counted_ok;
    end else if (stamp_mode_o) begin
      inc_o          = bit_start_i;
      cap_en_o       = frame_start_i;
      stamp_wr_req_o = any_ok;
    end
  end

endmodule

// File: rtl/fc_counter.sv
module fc_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;

  always_comb begin
    cnt_nxt_o = cnt_q + CNT_ONE;
    cnt_d     = cnt_q;
    ovf_d     = 1'b0;
    if (inc_i) begin
      cnt_d = cnt_nxt_o;
      ovf_d = (cnt_q == CNT_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R9: the wrap pulse coincides with a zero count
  p_ovf_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == '0));

  // R9: a pulse never lasts two cycles
  p_ovf_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> !ovf_q);

endmodule

// File: rtl/fc_capture.sv
module fc_capture #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stamp_mode_i,
  input  logic             cap_en_i,
  input  logic             wr_req_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             fire_o
);

  logic [CNT_W-1:0] cap_q, cap_d;
  logic             vld_q, vld_d;

  always_comb begin
    cap_d = cap_q;
    if (cap_en_i) cap_d = cnt_i;

    if (!stamp_mode_i)  vld_d = 1'b0;
    else if (cap_en_i)  vld_d = 1'b1;
    else if (wr_req_i)  vld_d = 1'b0;
    else                vld_d = vld_q;

    fire_o = wr_req_i & vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (cap_en_i) cap_q <= cap_d;
      vld_q <= vld_d;
    end
  end

  assign cap_o = cap_q;

  // R6: the capture takes the counter value of the start cycle
  p_cap_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en_i |=> (cap_q == $past(cnt_i)));

endmodule

// File: rtl/fc_handoff.sv
module fc_handoff #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned OBJ_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr_i,
  input  logic             stamp_fire_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] cap_i,
  input  logic [OBJ_W-1:0] idx_i,
  output logic             wr_o,
  output logic [OBJ_W-1:0] idx_o,
  output logic [CNT_W-1:0] val_o
);

  logic             wr_q, wr_d;
  logic [OBJ_W-1:0] idx_q;
  logic [CNT_W-1:0] val_q, val_d;

  always_comb begin
    wr_d  = cnt_wr_i | stamp_fire_i;
    val_d = cnt_wr_i ? cnt_nxt_i : cap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      idx_q <= '0;
      val_q <= '0;
    end else begin
      wr_q <= wr_d;
      if (wr_d) begin
        idx_q <= idx_i;
        val_q <= val_d;
      end
    end
  end

  assign wr_o  = wr_q;
  assign idx_o = idx_q;
  assign val_o = val_q;

  // R3/R7: a write and its payload are set by the same request
  p_wr_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_d |=> (idx_q == $past(idx_i)));

endmodule

// File: rtl/can_frame_stamp.sv
module can_frame_stamp
  import fc_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned OBJ_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       cnt_src_i,
  input  logic             bit_start_i,
  input  logic             frame_start_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic [OBJ_W-1:0] obj_idx_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             mo_wr_o,
  output logic [OBJ_W-1:0] mo_idx_o,
  output logic [CNT_W-1:0] mo_val_o,
  output logic             ovf_o
);

  logic             stamp_mode;
  logic             inc;
  logic             cap_en;
  logic             cnt_wr;
  logic             stamp_wr_req;
  logic             stamp_fire;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;

  fc_ctrl u_ctrl (
    .mode_i         (mode_i),
    .cnt_src_i      (cnt_src_i),
    .bit_start_i    (bit_start_i),
    .frame_start_i  (frame_start_i),
    .tx_ok_i        (tx_ok_i),
    .rx_ok_i        (rx_ok_i),
    .stamp_mode_o   (stamp_mode),
    .inc_o          (inc),
    .cap_en_o       (cap_en),
    .cnt_wr_o       (cnt_wr),
    .stamp_wr_req_o (stamp_wr_req)
  );

  fc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_i     (inc),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .ovf_o     (ovf_o)
  );

  fc_capture #(.CNT_W(CNT_W)) u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .stamp_mode_i (stamp_mode),
    .cap_en_i     (cap_en),
    .wr_req_i     (stamp_wr_req),
    .cnt_i        (cnt),
    .cap_o        (cap_val_o),
    .fire_o       (stamp_fire)
  );

  fc_handoff #(.CNT_W(CNT_W), .OBJ_W(OBJ_W)) u_ho (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_wr_i     (cnt_wr),
    .stamp_fire_i (stamp_fire),
    .cnt_nxt_i    (cnt_nxt),
    .cap_i        (cap_val_o),
    .idx_i        (obj_idx_i),
    .wr_o         (mo_wr_o),
    .idx_o        (mo_idx_o),
    .val_o        (mo_val_o)
  );

  // R10: bit-timing codes freeze the counter
  p_bt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i[1] |=> $stable(cnt));

  // R10: bit-timing codes issue no object write
  p_bt_nowr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i[1] |=> !mo_wr_o);

  // R3/R7: every write follows a success strobe
  p_wr_after_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mo_wr_o |-> $past(tx_ok_i | rx_ok_i));

  // R3: in counting mode the written value is the new count
  p_count_val_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && mo_wr_o) |-> (mo_val_o == cnt));

  // R5: success strobes leave the timestamp counter alone
  p_stamp_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && !bit_start_i) |=> $stable(cnt));

endmodule

// File: tb/sim_can_frame_stamp.sv
module sim_can_frame_stamp;

  logic        clk;
  logic        rst_n;
  logic [1:0]  mode;
  logic [1:0]  src;
  logic        bs, fs, tx, rx;
  logic [5:0]  idx;
  logic [15:0] cap_val;
  logic        mo_wr;
  logic [5:0]  mo_idx;
  logic [15:0] mo_val;
  logic        ovf;

  int checks;
  int fails;
  bit done;

  can_frame_stamp u0 (
    .clk (clk), .rst_n (rst_n), .mode_i (mode), .cnt_src_i (src),
    .bit_start_i (bs), .frame_start_i (fs), .tx_ok_i (tx), .rx_ok_i (rx),
    .obj_idx_i (idx), .cap_val_o (cap_val), .mo_wr_o (mo_wr),
    .mo_idx_o (mo_idx), .mo_val_o (mo_val), .ovf_o (ovf)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive one cycle of strobes, then sample just after the edge
  task automatic tick(logic b, logic f, logic t, logic r, logic [5:0] i);
    @(negedge clk);
    bs = b; fs = f; tx = t; rx = r; idx = i;
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    tick(1'b0, 1'b0, 1'b0, 1'b0, 6'd0);
  endtask

  task automatic t_reset();
    chk("R1 cap", cap_val, 16'h0);
    chk("R1 wr", {15'd0, mo_wr}, 16'h0);
    chk("R1 ovf", {15'd0, ovf}, 16'h0);
  endtask

  task automatic t_count();
    mode = 2'b00; src = 2'b11;
    tick(0, 0, 1, 0, 6'd5);
    chk("R3 wr tx", {15'd0, mo_wr}, 16'h1);
    chk("R3 val tx", mo_val, 16'd1);
    chk("R3 idx tx", {10'd0, mo_idx}, 16'd5);
    idle();
    chk("R3 pulse one cycle", {15'd0, mo_wr}, 16'h0);
    tick(0, 0, 0, 1, 6'd12);
    chk("R2 rx counted", mo_val, 16'd2);
    chk("R3 idx rx", {10'd0, mo_idx}, 16'd12);
    tick(0, 0, 1, 1, 6'd7);
    chk("R2 tx+rx once", mo_val, 16'd3);
    src = 2'b01;
    tick(0, 0, 0, 1, 6'd9);
    chk("R4 rx disabled no write", {15'd0, mo_wr}, 16'h0);
    tick(0, 0, 1, 0, 6'd2);
    chk("R4 count unchanged", mo_val, 16'd4);
    src = 2'b10;
    tick(0, 0, 1, 0, 6'd3);
    chk("R4 tx disabled no write", {15'd0, mo_wr}, 16'h0);
    idle();
  endtask

  task automatic t_stamp();
    mode = 2'b01;
    for (int k = 0; k < 10; k++) tick(1, 0, 0, 0, 6'd0);
    tick(0, 1, 0, 0, 6'd0);
    chk("R5/R6 capture after bits", cap_val, 16'd14);
    tick(1, 1, 0, 0, 6'd0);
    chk("R6 pre-increment capture", cap_val, 16'd14);
    for (int k = 0; k < 3; k++) tick(1, 0, 0, 0, 6'd0);
    tick(0, 0, 1, 0, 6'd9);
    chk("R7 wr", {15'd0, mo_wr}, 16'h1);
    chk("R7 val", mo_val, 16'd14);
    chk("R7 idx", {10'd0, mo_idx}, 16'd9);
    tick(0, 1, 0, 0, 6'd0);
    chk("R5 success no increment", cap_val, 16'd18);
    chk("R7 single pulse", {15'd0, mo_wr}, 16'h0);
  endtask

  task automatic t_abort();
    tick(0, 0, 0, 1, 6'd4);
    tick(0, 0, 0, 1, 6'd4);
    chk("R8 no write without new start", {15'd0, mo_wr}, 16'h0);
    tick(0, 1, 0, 0, 6'd0);
    tick(1, 0, 0, 0, 6'd0);
    tick(1, 0, 0, 0, 6'd0);
    tick(0, 1, 0, 0, 6'd0);
    chk("R8 capture overwritten", cap_val, 16'd20);
    tick(0, 0, 0, 1, 6'd3);
    chk("R8 write after restart", mo_val, 16'd20);
    chk("R8 wr", {15'd0, mo_wr}, 16'h1);
    idle();
  endtask

  task automatic t_btime(logic [1:0] code);
    mode = code;
    for (int k = 0; k < 5; k++) tick(1, 0, 0, 0, 6'd0);
    tick(0, 1, 1, 0, 6'd1);
    chk("R10 no write", {15'd0, mo_wr}, 16'h0);
    chk("R10 capture held", cap_val, 16'd20);
    mode = 2'b01;
    tick(0, 1, 0, 0, 6'd0);
    chk("R10 counter held", cap_val, 16'd20);
  endtask

  task automatic t_wrap();
    bit seen;
    seen = 1'b0;
    mode = 2'b01;
    for (int k = 0; k < 65515; k++) begin
      tick(1, 0, 0, 0, 6'd0);
      if (ovf) seen = 1'b1;
    end
    chk("R9 no early overflow", {15'd0, seen}, 16'h0);
    tick(0, 1, 0, 0, 6'd0);
    chk("R9 at max", cap_val, 16'hFFFF);
    tick(1, 0, 0, 0, 6'd0);
    chk("R9 pulse on wrap", {15'd0, ovf}, 16'h1);
    tick(0, 1, 0, 0, 6'd0);
    chk("R9 pulse one cycle", {15'd0, ovf}, 16'h0);
    chk("R9 wrapped to zero", cap_val, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; mode = 2'b00; src = 2'b00;
    bs = 0; fs = 0; tx = 0; rx = 0; idx = 6'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    t_reset();
    t_count();
    t_stamp();
    t_abort();
    t_btime(2'b10);
    t_btime(2'b11);
    t_wrap();
    summary();
    $finish;
  end

endmodule